// File: doc/BRIEF.md
# Four-Phase Pipeline Stage Controller

This block is the sequencing logic of a single stage in a self-timed pipeline, written in synchronous form. It has two request/acknowledge channels, one facing the upstream sender and one facing the downstream receiver. It also has a start/done pair that encloses a bundled-data datapath. A token enters when the upstream request rises. The controller raises start, waits for done, and then latches the datapath result and offers it downstream with a request. The acknowledge sent back upstream is held until the receiver acknowledges.

Every wire returns to zero before the next token is accepted. The release phase moves through the signals in the same order as the assertion phase: the upstream request falls, then start falls, then done falls, then the downstream request falls, then the downstream acknowledge falls, and finally the upstream acknowledge falls.

All three handshake inputs are resynchronised before the state machine uses them. An input that moves when the current state does not expect it to move is ignored, and it is reported on an error output.

Top module: `hs4_stage_ctrl`

## Requirements
- R1: While rst_ni is low, start_o, req_dn_o, ack_up_o, err_o and data_o are all 0, and the controller waits for req_up_i to rise.
- R2: With the controller idle, a rise of req_up_i raises start_o on the third rising clock edge after the change. Before that edge start_o stays low.
- R3: While start_o is high, a rise of done_i raises req_dn_o on the third rising clock edge. On that same edge data_o takes the value present on data_i.
- R4: While req_dn_o is high, a rise of ack_dn_i raises ack_up_o on the third rising clock edge. start_o and req_dn_o stay high at that point.
- R5: After ack_up_o is high, a fall of req_up_i lowers start_o on the third rising clock edge. req_dn_o and ack_up_o stay high.
- R6: After start_o falls, a fall of done_i lowers req_dn_o on the third rising clock edge. ack_up_o stays high.
- R7: After req_dn_o falls, a fall of ack_dn_i lowers ack_up_o on the third rising clock edge. All outputs are then low, and the next token may start.
- R8: data_o changes only on a capture (R3). It holds its value through the whole handshake and while idle, whatever data_i does in the meantime.
- R9: An input level that the current state does not expect causes no change in any output other than err_o. err_o is 1 from the third rising edge after the offending input appears until the third rising edge after it is removed. The unexpected levels are: done_i or ack_dn_i high while idle; req_up_i low or ack_dn_i high while computing; req_up_i or done_i low while the downstream request is up and unacknowledged.
- R10: Successive tokens, each completing the full four-phase cycle, are processed back to back with the correct data on every token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_up_i | input | 1 | Request from the upstream sender |
| ack_up_o | output | 1 | Acknowledge to the upstream sender |
| req_dn_o | output | 1 | Request to the downstream receiver |
| ack_dn_i | input | 1 | Acknowledge from the downstream receiver |
| start_o | output | 1 | Start of the datapath computation |
| done_i | input | 1 | Completion from the datapath |
| data_i | input | DATA_W | Datapath result, valid while done_i is high |
| data_o | output | DATA_W | Latched result, valid while req_dn_o is high |
| err_o | output | 1 | Out-of-order input seen |

## Verification
The state register drives the three handshake outputs directly. If the state is wrong, one of those outputs is therefore at the wrong level by the third edge after the input that should have moved it, and each step of the handshake is checked on exactly that edge and on the edge before it. A wrong capture shows on data_o in the same cycle that req_dn_o rises. A missing hold shows up once data_i is scrambled while the token is still outstanding. A protocol fault that is not detected, or a state that moves on a bad input, shows as err_o staying low, or as a handshake output moving while err_o is high.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPUTE,
    ST_REQ_OUT,
    ST_WAIT_ACK,
    ST_RESET_START,
    ST_RESET_OUT,
    ST_RESET_ACK
  } hs_state_e;

  typedef struct packed {
    logic req_up;
    logic done;
    logic ack_dn;
  } hs_in_t;

  localparam int unsigned HS_IN_W = $bits(hs_in_t);
endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
    end
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/hs4_data_hold.sv
module hs4_data_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_o <= '0;
    else if (capture_i) data_o <= data_i;
  end
endmodule

// File: rtl/hs4_fsm.sv
module hs4_fsm
  import hs4_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  hs_in_t in_i,
  output logic   start_o,
  output logic   req_dn_o,
  output logic   ack_up_o,
  output logic   capture_o,
  output logic   err_o
);
  hs_state_e state_q, state_d;
  logic      viol;

  always_comb begin
    state_d = state_q;
    viol    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        viol = in_i.done | in_i.ack_dn;
        if (!viol && in_i.req_up) state_d = ST_COMPUTE;
      end
      ST_COMPUTE: begin
        viol = !in_i.req_up | in_i.ack_dn;
        if (!viol && in_i.done) state_d = ST_REQ_OUT;
      end
      ST_REQ_OUT: begin
        viol = !in_i.req_up | !in_i.done;
        if (!viol && in_i.ack_dn) state_d = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        viol = !in_i.done | !in_i.ack_dn;
        if (!viol && !in_i.req_up) state_d = ST_RESET_START;
      end
      ST_RESET_START: begin
        viol = in_i.req_up | !in_i.ack_dn;
        if (!viol && !in_i.done) state_d = ST_RESET_OUT;
      end
      ST_RESET_OUT: begin
        viol = in_i.req_up | in_i.done;
        if (!viol && !in_i.ack_dn) state_d = ST_RESET_ACK;
      end
      ST_RESET_ACK: begin
        viol    = in_i.done | in_i.ack_dn;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_o   <= viol;
    end
  end

  assign capture_o = (state_q == ST_COMPUTE) && (state_d == ST_REQ_OUT);
  assign start_o   = (state_q == ST_COMPUTE) || (state_q == ST_REQ_OUT) ||
                     (state_q == ST_WAIT_ACK);
  assign req_dn_o  = (state_q == ST_REQ_OUT) || (state_q == ST_WAIT_ACK) ||
                     (state_q == ST_RESET_START);
  assign ack_up_o  = (state_q == ST_WAIT_ACK) || (state_q == ST_RESET_START) ||
                     (state_q == ST_RESET_OUT);

  p_start_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(in_i.req_up) && !req_dn_o);
  p_req_after_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_dn_o) |-> $past(in_i.done) && start_o);
  p_ack_after_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_up_o) |-> $past(in_i.ack_dn) && req_dn_o && start_o);
  p_start_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_o) |-> !$past(in_i.req_up) && req_dn_o && ack_up_o);
  p_req_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_dn_o) |-> !$past(in_i.done) && ack_up_o && !start_o);
  p_ack_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_up_o) |-> !req_dn_o && !start_o && !$past(in_i.ack_dn));
  p_err_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && ($past(state_q) != ST_RESET_ACK) |-> state_q == $past(state_q));
endmodule

// File: rtl/hs4_stage_ctrl.sv
module hs4_stage_ctrl
  import hs4_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_up_i,
  output logic              ack_up_o,
  output logic              req_dn_o,
  input  logic              ack_dn_i,
  output logic              start_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  hs_in_t             raw_in, sync_in;
  logic [HS_IN_W-1:0] sync_bits;
  logic               capture;

  assign raw_in = '{req_up: req_up_i, done: done_i, ack_dn: ack_dn_i};

  hs4_sync #(.WIDTH(HS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_bits)
  );

  assign sync_in = hs_in_t'(sync_bits);

  hs4_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_i     (sync_in),
    .start_o  (start_o),
    .req_dn_o (req_dn_o),
    .ack_up_o (ack_up_o),
    .capture_o(capture),
    .err_o    (err_o)
  );

  hs4_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .data_i   (data_i),
    .data_o   (data_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_reset_low_r1: assert (!start_o && !req_dn_o && !ack_up_o && !err_o && data_o == '0);
    end
  end

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_dn_o && $past(req_dn_o) |-> $stable(data_o));
  p_ack_implies_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_up_o) |-> req_dn_o);
endmodule

// File: tb/tb_hs4_stage_ctrl.sv
module tb_hs4_stage_ctrl;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_up, ack_dn, done;
  logic [DATA_W-1:0] din;
  logic              ack_up, req_dn, start, err;
  logic [DATA_W-1:0] dout;
  int                n_checks = 0;
  int                n_errors = 0;

  always #2 clk = ~clk;

  hs4_stage_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_up_i(req_up),
    .ack_up_o(ack_up),
    .req_dn_o(req_dn),
    .ack_dn_i(ack_dn),
    .start_o (start),
    .done_i  (done),
    .data_i  (din),
    .data_o  (dout),
    .err_o   (err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // outputs packed as {start, req_dn, ack_up, err}
  function automatic logic [3:0] outs();
    return {start, req_dn, ack_up, err};
  endfunction

  task automatic run_token(input logic [DATA_W-1:0] d);
    req_up = 1'b1;
    tick(2); check("R2 start not yet", 32'(outs()), 32'b0000);
    tick(1); check("R2 start rises", 32'(outs()), 32'b1000);
    din = d; done = 1'b1;
    tick(2); check("R3 req_dn not yet", 32'(outs()), 32'b1000);
    tick(1); check("R3 req_dn rises", 32'(outs()), 32'b1100);
    check("R3 data captured", 32'(dout), 32'(d));
    din = ~d;
    ack_dn = 1'b1;
    tick(2); check("R4 ack_up not yet", 32'(outs()), 32'b1100);
    tick(1); check("R4 ack_up rises", 32'(outs()), 32'b1110);
    check("R8 data held", 32'(dout), 32'(d));
    req_up = 1'b0;
    tick(3); check("R5 start falls", 32'(outs()), 32'b0110);
    done = 1'b0;
    tick(3); check("R6 req_dn falls", 32'(outs()), 32'b0010);
    din = d ^ 8'h5A;
    ack_dn = 1'b0;
    tick(2); check("R7 ack_up not yet", 32'(outs()), 32'b0010);
    tick(1); check("R7 ack_up falls", 32'(outs()), 32'b0000);
    tick(1); check("R8 data held idle", 32'(dout), 32'(d));
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_up = 1'b0; ack_dn = 1'b0; done = 1'b0; din = 8'hA5;
    tick(3);
    check("R1 outputs low in reset", 32'(outs()), 32'b0000);
    check("R1 data low in reset", 32'(dout), 32'h0);
    rst_n = 1'b1;
    tick(2);
    check("R1 idle after reset", 32'(outs()), 32'b0000);

    // R9: unexpected done while idle
    done = 1'b1;
    tick(2); check("R9 err not yet", 32'(outs()), 32'b0000);
    tick(1); check("R9 err idle done", 32'(outs()), 32'b0001);
    done = 1'b0;
    tick(2); check("R9 err still", 32'(outs()), 32'b0001);
    tick(1); check("R9 err clears", 32'(outs()), 32'b0000);
    // R9: unexpected ack_dn while computing
    req_up = 1'b1;
    tick(3); check("R2 start rises", 32'(outs()), 32'b1000);
    ack_dn = 1'b1;
    tick(3); check("R9 err compute ack", 32'(outs()), 32'b1001);
    ack_dn = 1'b0;
    tick(3); check("R9 err clears compute", 32'(outs()), 32'b1000);
    din = 8'h3C; done = 1'b1;
    tick(3); check("R3 req_dn after err", 32'(outs()), 32'b1100);
    check("R3 data after err", 32'(dout), 32'h3C);
    // R9: req_up dropped before downstream ack
    req_up = 1'b0;
    tick(3); check("R9 err early req drop", 32'(outs()), 32'b1101);
    req_up = 1'b1;
    tick(3); check("R9 err clears req", 32'(outs()), 32'b1100);
    ack_dn = 1'b1;
    tick(3); check("R4 ack_up after err", 32'(outs()), 32'b1110);
    req_up = 1'b0; tick(3);
    done = 1'b0; tick(3);
    ack_dn = 1'b0; tick(3);
    check("R7 idle after recovery", 32'(outs()), 32'b0000);
    tick(1);

    // R10: back-to-back tokens sweeping data values
    for (int i = 0; i < 24; i++) begin
      run_token(DATA_W'((i * 37 + 5) & 8'hFF));
    end
    run_token(8'h00);
    run_token(8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule